// File: doc/BRIEF.md
# SPI EEPROM Slave with Block Protection

This block is the digital front end of a byte-wide serial nonvolatile memory on an SPI bus. A host selects it with an active-low chip select and clocks in an instruction byte. Depending on the instruction, a two-byte address and data bytes follow, or the block returns data on the serial output. The storage array is modelled as an internal register array of 2^ADDR_W bytes. The deployed setting is ADDR_W = 14, which gives 16384 bytes. A smaller default keeps elaboration light.

All SPI pins are resynchronised to the system clock, and SCK edges are found by oversampling. Writes are guarded in three ways. A write-enable latch must be set first. Two protect bits in the status register lock part of the array. A write-protect pin can freeze the status register. An accepted write is collected in a page buffer and committed when chip select rises. It then runs as a self-timed busy interval of WRITE_CYCLES clocks. A hold input pauses a transfer at any bit.

Top module: `eeprom_spi_slave`

## Requirements
- R1: SPI clock modes 0 and 3 both work. SI is captured on rising SCK and SO changes on falling SCK, with the most significant bit first, whatever idle level SCK has when select falls.
- R2: Instruction 0x05 returns the status byte {wp_enable, 0, 0, 0, protect[1:0], write_enable, busy}, bit 7 down to bit 0. After reset the status byte is 0x00.
- R3: The protect field encodes 00 as no lock, 01 as the upper quarter of the array, 10 as the upper half and 11 as the whole array. A write whose page lies in the locked range changes nothing and starts no busy interval.
- R4: Instruction 0x01 followed by one byte updates wp_enable from bit 7 and protect from bits 3:2. It is rejected while wp_enable is 1 and wp_n is low.
- R5: While hold_n is low during a selected transfer, so_oe is low and SCK, SI and select changes are ignored. Once hold_n returns high, the transfer continues at the same bit.
- R6: Instruction 0x06 sets write_enable and 0x04 clears it. With write_enable clear, instructions 0x02 and 0x01 have no effect.
- R7: A committed write sets busy for WRITE_CYCLES clocks after select rises. write_enable clears when the interval ends.
- R8: Instruction 0x03 takes a 16-bit address, high byte first, and ignores the bits above ADDR_W. It then streams bytes with the address incrementing, and the address wraps from the last byte to 0.
- R9: Instruction 0x02 writes bytes starting at its address. The low 5 address bits wrap inside the current 32-byte page.
- R10: A write or a status write commits only if select rises on a byte boundary.
- R11: While busy, only instruction 0x05 is decoded. Any other instruction, including a status write, is ignored.
- R12: so_oe is low whenever the block is deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pauses the transfer while low |
| wp_n | input | 1 | Write-protect pin for the status register, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
The assertions assume that every SPI pin holds each level for longer than the synchroniser delay. Without that, a select, hold or SCK change could be seen out of order relative to another pin. They also assume that hold_n falls and rises only while SCK is steady, so that releasing hold creates no SCK edge. The stimulus keeps each SCK phase at six system clocks and lowers hold_n only while SCK is high. It returns SCK to that same level before releasing hold.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADH, PH_ADL, PH_RDAT, PH_WDAT, PH_WSR, PH_RSR, PH_SKIP
  } phase_t;

  // top: the two most significant address bits of the target page
  function automatic logic lock_hit(input logic [1:0] prot, input logic [1:0] top);
    case (prot)
      2'b00:   return 1'b0;
      2'b01:   return top == 2'b11;
      2'b10:   return top[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= RST_VAL;
        else        stg[k] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= RST_VAL;
        else        stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard
  import eeprom_pkg::*;
(
  input  logic       wel,
  input  logic       busy,
  input  logic [1:0] prot,
  input  logic       wpen,
  input  logic       wp_n_s,
  input  logic [1:0] page_top,
  output logic       arr_ok,
  output logic       sr_ok
);
  assign arr_ok = wel && !busy && !lock_hit(prot, page_top);
  assign sr_ok  = wel && !busy && !(wpen && !wp_n_s);
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_B = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  function automatic logic [ADDR_W-1:0] rd_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] wr_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  logic [4:0] pins_s;
  logic s_cs_n, s_hold_n, s_wp_n, s_sck, s_si;

  spi_pin_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, hold_n, wp_n, sck, si}), .dout(pins_s)
  );
  assign {s_cs_n, s_hold_n, s_wp_n, s_sck, s_si} = pins_s;

  logic              sck_d, sel_q;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx_sr;
  phase_t            ph;
  logic [ADDR_W-9:0] addr_hi;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        tx_byte, out_sr, sr_data;
  logic              tx_vld, rd_req, sr_pend;
  logic [PAGE_B-1:0] pmask;
  logic              wel, wpen, busy;
  logic [1:0]        prot;
  logic [CNT_W-1:0]  busy_cnt;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE_B];

  // named events for the checker
  logic held, active, cs_rise_ev, cs_fall_ev, sck_rise, sck_fall, byte_done;
  logic arr_ok, sr_ok, commit_arr, commit_sr;
  logic [7:0] rx_byte, status_w;
  logic [ADDR_W-1:0] addr_in;
  logic [1:0] page_top;

  assign held       = sel_q && !s_hold_n;
  assign active     = sel_q && !held;
  assign cs_rise_ev = active && s_cs_n;
  assign cs_fall_ev = !sel_q && !s_cs_n;
  assign sck_rise   = active && !s_cs_n && s_sck && !sck_d;
  assign sck_fall   = active && !s_cs_n && !s_sck && sck_d;
  assign byte_done  = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte    = {rx_sr, s_si};
  assign addr_in    = {addr_hi, rx_byte};
  assign status_w   = {wpen, 3'b000, prot, wel, busy};
  assign page_top   = addr_q[ADDR_W-1:ADDR_W-2];

  eeprom_wr_guard u_guard (
    .wel(wel), .busy(busy), .prot(prot), .wpen(wpen), .wp_n_s(s_wp_n),
    .page_top(page_top), .arr_ok(arr_ok), .sr_ok(sr_ok)
  );

  assign commit_arr = cs_rise_ev && ph == PH_WDAT && bit_cnt == 3'd0 && |pmask && arr_ok;
  assign commit_sr  = cs_rise_ev && sr_pend && bit_cnt == 3'd0 && sr_ok;

  assign so    = out_sr[7];
  assign so_oe = active && !s_cs_n && (ph == PH_RDAT || ph == PH_RSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; sel_q <= 1'b0; bit_cnt <= '0; rx_sr <= '0; ph <= PH_CMD;
      addr_hi <= '0; addr_q <= '0; tx_byte <= '0; tx_vld <= 1'b0; out_sr <= '0;
      rd_req <= 1'b0; pmask <= '0; sr_data <= '0; sr_pend <= 1'b0;
      wel <= 1'b0; prot <= '0; wpen <= 1'b0; busy <= 1'b0; busy_cnt <= '0;
    end else begin
      sck_d <= s_sck;
      if (!held) sel_q <= !s_cs_n;
      if (cs_fall_ev || cs_rise_ev) begin
        bit_cnt <= '0; ph <= PH_CMD; tx_vld <= 1'b0; sr_pend <= 1'b0; pmask <= '0;
      end else begin
        if (sck_rise) begin
          rx_sr   <= {rx_sr[5:0], s_si};
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0 && tx_vld) begin
            out_sr <= tx_byte;
            tx_vld <= 1'b0;
          end else begin
            out_sr <= {out_sr[6:0], 1'b0};
          end
        end
        if (byte_done) begin
          case (ph)
            PH_CMD: begin
              if (busy && rx_byte != OP_RDSR) ph <= PH_SKIP;
              else begin
                case (rx_byte)
                  OP_WREN:  begin wel <= 1'b1; ph <= PH_SKIP; end
                  OP_WRDI:  begin wel <= 1'b0; ph <= PH_SKIP; end
                  OP_RDSR:  begin tx_byte <= status_w; tx_vld <= 1'b1; ph <= PH_RSR; end
                  OP_WRSR:  ph <= wel ? PH_WSR : PH_SKIP;
                  OP_READ:  begin rd_req <= 1'b1; ph <= PH_ADH; end
                  OP_WRITE: begin rd_req <= 1'b0; ph <= wel ? PH_ADH : PH_SKIP; end
                  default:  ph <= PH_SKIP;
                endcase
              end
            end
            PH_ADH: begin addr_hi <= rx_byte[ADDR_W-9:0]; ph <= PH_ADL; end
            PH_ADL: begin
              if (rd_req) begin
                tx_byte <= mem[addr_in]; tx_vld <= 1'b1;
                addr_q  <= rd_step(addr_in); ph <= PH_RDAT;
              end else begin
                addr_q <= addr_in; ph <= PH_WDAT;
              end
            end
            PH_RDAT: begin
              tx_byte <= mem[addr_q]; tx_vld <= 1'b1; addr_q <= rd_step(addr_q);
            end
            PH_RSR:  begin tx_byte <= status_w; tx_vld <= 1'b1; end
            PH_WDAT: begin
              pmask[addr_q[PAGE_W-1:0]] <= 1'b1;
              addr_q <= wr_step(addr_q);
            end
            PH_WSR:  begin sr_data <= rx_byte; sr_pend <= 1'b1; ph <= PH_SKIP; end
            default: ;
          endcase
        end
      end
      if (commit_sr) begin
        prot <= sr_data[3:2];
        wpen <= sr_data[7];
      end
      if (commit_arr || commit_sr) begin
        busy     <= 1'b1;
        busy_cnt <= CNT_W'(WRITE_CYCLES - 1);
      end else if (busy) begin
        if (busy_cnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          busy_cnt <= busy_cnt - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (byte_done && ph == PH_WDAT) pbuf[addr_q[PAGE_W-1:0]] <= rx_byte;

  always_ff @(posedge clk)
    if (commit_arr)
      for (int i = 0; i < PAGE_B; i++)
        if (pmask[i]) mem[{addr_q[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];

endmodule

// File: rtl/eeprom_spi_chk.sv
module eeprom_spi_chk
  import eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       held,
  input logic       commit_arr,
  input logic       commit_sr,
  input logic       busy,
  input logic       wel,
  input logic       wpen,
  input logic       s_wp_n,
  input logic [1:0] prot,
  input logic [1:0] page_top
);
  // R12
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);
  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);
  // R6
  latch_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_arr || commit_sr) |-> wel);
  // R3
  locked_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_arr |-> !lock_hit(prot, page_top));
  // R4
  wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_sr |-> !(wpen && !s_wp_n));
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_arr || commit_sr) |=> busy);
  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(commit_arr || commit_sr));
endmodule

bind eeprom_spi_slave eeprom_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .held(held),
  .commit_arr(commit_arr), .commit_sr(commit_sr), .busy(busy), .wel(wel),
  .wpen(wpen), .s_wp_n(s_wp_n), .prot(prot), .page_top(page_top)
);

// File: tb/sim_eeprom_spi_slave.sv
`timescale 1ns/1ps
module sim_eeprom_spi_slave;
  localparam int H = 6;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  logic so, so_oe;
  logic cpol = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] dbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] v, r;

  eeprom_spi_slave #(.ADDR_W(11), .PAGE_W(5), .WRITE_CYCLES(600), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  always #10 clk = ~clk;

  // {address as sent, data}
  localparam logic [23:0] VEC [4] = '{
    {16'h0010, 8'h3C}, {16'h0123, 8'hA7}, {16'h07FF, 8'h5E}, {16'h0000, 8'hC1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = cpol; cs_n = 0; wt(H);
  endtask

  task automatic desel();
    sck = cpol; wt(H); cs_n = 1; wt(3 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int hold_at);
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) begin
        hold_n = 0; wt(H);
        chk("R5 so_oe during hold", so_oe, 0);
        for (int t = 0; t < 2; t++) begin
          sck = 0; si = ~si; wt(H); sck = 1; wt(H);
        end
        hold_n = 1; wt(H);
      end
      sck = 0; si = tx[i]; wt(H);
      rx[i] = so;
      sck = 1; wt(H);
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] x;
    sel(); xfer(op, x, -1); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] x;
    sel(); xfer(8'h05, x, -1); xfer(8'h00, s, -1); desel();
  endtask

  task automatic wrsr(input logic [7:0] s);
    logic [7:0] x;
    sel(); xfer(8'h01, x, -1); xfer(s, x, -1); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] x;
    sel(); xfer(8'h02, x, -1); xfer(a[15:8], x, -1); xfer(a[7:0], x, -1);
    for (int k = 0; k < n; k++) xfer(dbuf[k], x, -1);
    desel();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] x;
    sel(); xfer(8'h03, x, -1); xfer(a[15:8], x, -1); xfer(a[7:0], x, -1);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k], -1);
    desel();
  endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] d);
    cmd1(8'h06); dbuf[0] = d; wr(a, 1); wait_ready();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wt(5); rst_n = 1; wt(5);
    // R12 and R2: reset state
    chk("R12 so_oe after reset", so_oe, 0);
    rdsr(v); chk("R2 status after reset", v, 8'h00);
    // R6: latch set and clear
    cmd1(8'h06); rdsr(v); chk("R6 latch set", v, 8'h02);
    cmd1(8'h04); rdsr(v); chk("R6 latch cleared", v, 8'h00);

    // R1: table of byte writes and readbacks in mode 0
    foreach (VEC[k]) begin
      wr1(VEC[k][23:8], VEC[k][7:0]);
      rd(VEC[k][23:8], 1);
      chk("R1 byte readback", rbuf[0], VEC[k][7:0]);
    end

    // R8: high address bits ignored, streaming wrap to 0
    rd(16'hF810, 1); chk("R8 high bits ignored", rbuf[0], 8'h3C);
    rd(16'h07FF, 2);
    chk("R8 stream last byte", rbuf[0], 8'h5E);
    chk("R8 stream wraps to 0", rbuf[1], 8'hC1);
    rd(16'h0122, 2); chk("R8 increment", rbuf[1], 8'hA7);

    // R6: write without the latch
    dbuf[0] = 8'hFF; wr(16'h0010, 1); wait_ready();
    rd(16'h0010, 1); chk("R6 write without latch ignored", rbuf[0], 8'h3C);
    rdsr(v); chk("R6 no busy without latch", v, 8'h00);

    // R7, R11: busy interval and instructions ignored while busy
    cmd1(8'h06); dbuf[0] = 8'h99; wr(16'h0200, 1);
    rdsr(v); chk("R7 busy and latch during cycle", v, 8'h03);
    wrsr(8'h0C);
    wait_ready();
    rdsr(v); chk("R11 status write during busy ignored, R7 latch cleared", v, 8'h00);
    rd(16'h0200, 1); chk("R7 data committed", rbuf[0], 8'h99);

    // R9: page wrap
    cmd1(8'h06);
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
    wr(16'h003E, 4); wait_ready();
    rd(16'h003E, 2);
    chk("R9 offset 30", rbuf[0], 8'h11); chk("R9 offset 31", rbuf[1], 8'h22);
    rd(16'h0020, 2);
    chk("R9 wrapped offset 0", rbuf[0], 8'h33); chk("R9 wrapped offset 1", rbuf[1], 8'h44);

    // R10: select rises mid-byte
    wr1(16'h0300, 8'h5A);
    cmd1(8'h06);
    sel(); xfer(8'h02, r, -1); xfer(8'h03, r, -1); xfer(8'h00, r, -1); xfer(8'hA5, r, -1);
    for (int b = 0; b < 3; b++) begin sck = 0; si = 1; wt(H); sck = 1; wt(H); end
    desel();
    rdsr(v); chk("R10 no cycle on partial byte", v, 8'h02);
    rd(16'h0300, 1); chk("R10 data unchanged", rbuf[0], 8'h5A);

    // R3: block protection
    wr1(16'h0700, 8'hA5); wr1(16'h0500, 8'h5A); wr1(16'h0100, 8'h11);
    cmd1(8'h06); wrsr(8'h04); wait_ready();
    rdsr(v); chk("R3 quarter setting", v, 8'h04);
    wr1(16'h0700, 8'hFF); rd(16'h0700, 1); chk("R3 upper quarter locked", rbuf[0], 8'hA5);
    wr1(16'h0500, 8'h77); rd(16'h0500, 1); chk("R3 below quarter open", rbuf[0], 8'h77);
    cmd1(8'h06); wrsr(8'h08); wait_ready();
    wr1(16'h0500, 8'h99); rd(16'h0500, 1); chk("R3 upper half locked", rbuf[0], 8'h77);
    cmd1(8'h06); wrsr(8'h0C); wait_ready();
    wr1(16'h0100, 8'h22); rd(16'h0100, 1); chk("R3 whole array locked", rbuf[0], 8'h11);
    cmd1(8'h06); wrsr(8'h00); wait_ready();
    rdsr(v); chk("R3 lock removed", v, 8'h00);

    // R4: write-protect pin
    cmd1(8'h06); wrsr(8'h80); wait_ready();
    rdsr(v); chk("R4 pin enable set", v, 8'h80);
    wp_n = 0; cmd1(8'h06); wrsr(8'h8C); wait_ready();
    rdsr(v); chk("R4 status frozen by pin", v, 8'h82);
    wp_n = 1; wrsr(8'h0C); wait_ready();
    rdsr(v); chk("R4 accepted with pin high", v, 8'h0C);
    cmd1(8'h06); wrsr(8'h00); wait_ready();

    // R5: hold in the middle of a read byte
    sel(); xfer(8'h03, r, -1); xfer(8'h01, r, -1); xfer(8'h23, r, -1);
    xfer(8'h00, v, 3);
    desel();
    chk("R5 byte intact across hold", v, 8'hA7);
    chk("R12 so_oe after deselect", so_oe, 0);

    // R1: mode 3
    cpol = 1; sck = 1; wt(3 * H);
    rd(16'h0123, 1); chk("R1 mode 3 read", rbuf[0], 8'hA7);
    wr1(16'h0124, 8'h6D);
    rd(16'h0123, 2); chk("R1 mode 3 write then read", rbuf[1], 8'h6D);
    cpol = 0; sck = 0; wt(3 * H);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule